// File: doc/BRIEF.md
# Adjacent Instruction Pair Fusion Detector

This block sits between the decoded-instruction buffer and the issue stage of an in-order pipeline. Each cycle it looks at the two oldest decoded records, called the older slot and the younger slot. It decides whether the two can issue together as one fused operation, with the intermediate data-register value forwarded inside that issue slot.

Two shapes are merged. The first is a load-type move into a data register followed by an ALU operation that reads that register. The second is an ALU operation writing a data register followed by a store-type move of that register. Every other case passes the older record through alone.

The block tells the buffer how many records it consumed: zero, one or two. When only the older record is present, it can optionally hold it back for a bounded number of cycles so that a partner can arrive. A flush cancels any hold and suppresses issue in the same cycle.

Top module: `fuse_pair_detect`

## Requirements
- R1: Record layout, from MSB to LSB of the 22-bit word:
  - class [21:20]: 0 other, 1 move, 2 ALU.
  - size [19:18]: 0 byte, 1 word, 2 long.
  - source register [17:14] and destination register [13:10]. Bit 3 of each register field set means address register, clear means data register.
  - memory-side mode [9:7]: 0 data direct, 1 address direct, 2 indirect, 3 postincrement, 4 predecrement, 5 to 7 any form needing extension words.
  - direction [6]: 0 means the memory side is the source (load move), 1 means it is the destination (store move).
  - address register number [5:3].
  - length in 16-bit words [2:0].
- R1 (continued): An older load move into data register Dn, followed by a younger ALU record whose source is Dn, is fused. The outputs are fuse_o=1, consume_o=2 and desc_kind_o=2.
- R2: An older ALU record writing data register Dn, followed by a younger store move whose source is Dn, is fused. The outputs are fuse_o=1, consume_o=2 and desc_kind_o=3.
- R3: Fusion needs size code 2 (long) in both records. Any other size yields a single issue.
- R4: Fusion needs a length of exactly 1 word in both records.
- R5: Fusion needs the move's memory-side mode to be 0, 2, 3 or 4. Modes 1, 5, 6 and 7 prevent it.
- R6: The linking register must be a data register and must match exactly. Records of an interleaved sequence whose adjacent pairs are not dependent are never fused.
- R7: An issue without fusion gives issue_valid_o=1, fuse_o=0, consume_o=1 and desc_kind_o=1. It also gives desc_first_o equal to the older record, and desc_second_o, desc_wb_en_o and desc_wb_reg_o all zero.
- R8: A fused issue gives desc_first_o equal to the older record, desc_second_o equal to the younger record, desc_wb_en_o=1, and desc_wb_reg_o equal to Dn.
- R9: With hold_en_i=0, a lone older record (young_valid_i=0) issues alone at once.
- R10: With hold_en_i=1, a lone older record that could start a pair is held back for at most MAX_WAIT cycles (default 1). While it is held, issue_valid_o=0 and consume_o=0. A partner arriving during the hold is fused.
- R11: flush_i=1 forces issue_valid_o=0, fuse_o=0 and consume_o=0, and cancels any hold in progress.
- R12: With old_valid_i=0, nothing issues: issue_valid_o=0, consume_o=0, desc_kind_o=0 and all descriptor fields are zero. This is also the state after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Cancel issue and any hold this cycle |
| hold_en_i | input | 1 | Allow waiting for a partner |
| old_valid_i | input | 1 | Older slot holds a record |
| old_insn_i | input | 22 | Older decoded record |
| young_valid_i | input | 1 | Younger slot holds a record |
| young_insn_i | input | 22 | Younger decoded record |
| issue_valid_o | output | 1 | An operation issues this cycle |
| fuse_o | output | 1 | Issued operation is a fused pair |
| consume_o | output | 2 | Records taken from the buffer |
| desc_kind_o | output | 2 | 0 none, 1 single, 2 load-then-ALU, 3 ALU-then-store |
| desc_first_o | output | 22 | Older record as issued |
| desc_second_o | output | 22 | Younger record when fused |
| desc_wb_en_o | output | 1 | Linking data register is written |
| desc_wb_reg_o | output | 3 | Number of the linking data register |

## Verification
The bench walks each qualifying limit to the edge of its range: every size code, a two-word length in either slot, every memory-side mode, and linking registers that are mismatched or are address registers. A design that loosened any one of these would fuse and report a consumed count of two where a single issue is due. The interleaved four-record sequence is replayed as a sliding window, so a detector that looked past its neighbour would show up at once. The hold window is probed in three ways: with a partner arriving late, with a lone record that could not start a pair, and with a flush in mid-hold. A counter that failed to clear or to saturate would either stall forever or never stall again.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
  localparam int CLS_W  = 2;
  localparam int SIZE_W = 2;
  localparam int REG_W  = 4;
  localparam int MODE_W = 3;
  localparam int AREG_W = 3;
  localparam int LEN_W  = 3;
  localparam int INSN_W = CLS_W + SIZE_W + 2*REG_W + MODE_W + 1 + AREG_W + LEN_W;
  localparam int DNUM_W = REG_W - 1;

  typedef enum logic [CLS_W-1:0] {
    CLS_OTHER = 2'd0,
    CLS_MOVE  = 2'd1,
    CLS_ALU   = 2'd2,
    CLS_RSVD  = 2'd3
  } cls_e;

  localparam logic [SIZE_W-1:0] SZ_LONG = 2'd2;
  localparam logic [LEN_W-1:0]  LEN_ONE = 3'd1;

  typedef enum logic [MODE_W-1:0] {
    MD_DREG  = 3'd0,
    MD_AREG  = 3'd1,
    MD_IND   = 3'd2,
    MD_PINC  = 3'd3,
    MD_PDEC  = 3'd4,
    MD_EXT5  = 3'd5,
    MD_EXT6  = 3'd6,
    MD_EXT7  = 3'd7
  } mode_e;

  typedef enum logic [1:0] {
    KIND_NONE     = 2'd0,
    KIND_SINGLE   = 2'd1,
    KIND_LOAD_OP  = 2'd2,
    KIND_OP_STORE = 2'd3
  } kind_e;

  typedef struct packed {
    cls_e              cls;
    logic [SIZE_W-1:0] size;
    logic [REG_W-1:0]  src;
    logic [REG_W-1:0]  dst;
    mode_e             mode;
    logic              to_mem;
    logic [AREG_W-1:0] areg;
    logic [LEN_W-1:0]  len;
  } insn_t;

  function automatic logic mode_short(mode_e m);
    return (m == MD_DREG) || (m == MD_IND) || (m == MD_PINC) || (m == MD_PDEC);
  endfunction
endpackage

// File: rtl/fuse_slot_qual.sv
module fuse_slot_qual
  import fuse_pkg::*;
#(
  parameter bit LEAD = 1'b1
) (
  input  insn_t            insn_i,
  output logic             base_ok_o,
  output logic             form_a_o,
  output logic             form_b_o,
  output logic [REG_W-1:0] key_reg_o
);
  assign base_ok_o = (insn_i.size == SZ_LONG) && (insn_i.len == LEN_ONE);

  generate
    if (LEAD) begin : g_lead
      logic unused_lead;
      assign unused_lead = ^{insn_i.src, insn_i.areg};
      // a: load move into Dn, b: ALU writing Dn
      assign form_a_o  = (insn_i.cls == CLS_MOVE) && !insn_i.to_mem &&
                         !insn_i.dst[REG_W-1] && mode_short(insn_i.mode);
      assign form_b_o  = (insn_i.cls == CLS_ALU) && !insn_i.dst[REG_W-1];
      assign key_reg_o = insn_i.dst;
    end else begin : g_tail
      logic unused_tail;
      assign unused_tail = ^{insn_i.dst, insn_i.areg};
      // a: ALU reading Dn, b: store move of Dn
      assign form_a_o  = (insn_i.cls == CLS_ALU) && !insn_i.src[REG_W-1];
      assign form_b_o  = (insn_i.cls == CLS_MOVE) && insn_i.to_mem &&
                         !insn_i.src[REG_W-1] && mode_short(insn_i.mode);
      assign key_reg_o = insn_i.src;
    end
  endgenerate
endmodule

// File: rtl/fuse_pair_rules.sv
module fuse_pair_rules
  import fuse_pkg::*;
(
  input  logic             young_valid_i,
  input  logic             o_base_i,
  input  logic             o_load_i,
  input  logic             o_alu_i,
  input  logic [REG_W-1:0] o_key_i,
  input  logic             y_base_i,
  input  logic             y_alu_i,
  input  logic             y_store_i,
  input  logic [REG_W-1:0] y_key_i,
  output logic             load_pair_o,
  output logic             store_pair_o,
  output logic             lead_cand_o
);
  logic both_ok;
  logic linked;

  assign both_ok      = young_valid_i && o_base_i && y_base_i;
  assign linked       = (o_key_i == y_key_i);
  assign load_pair_o  = both_ok && linked && o_load_i && y_alu_i;
  assign store_pair_o = both_ok && linked && o_alu_i && y_store_i;
  assign lead_cand_o  = o_base_i && (o_load_i || o_alu_i);
endmodule

// File: rtl/fuse_wait_ctrl.sv
module fuse_wait_ctrl #(
  parameter int MAX_WAIT = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flush_i,
  input  logic hold_en_i,
  input  logic old_valid_i,
  input  logic young_valid_i,
  input  logic lead_cand_i,
  output logic stall_o
);
  localparam int CNT_W = $clog2(MAX_WAIT + 1) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_WAIT);

  logic [CNT_W-1:0] wait_q;

  assign stall_o = hold_en_i && old_valid_i && !young_valid_i && lead_cand_i &&
                   !flush_i && (wait_q < CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      wait_q <= '0;
    else if (stall_o) wait_q <= wait_q + 1'b1;
    else              wait_q <= '0;
  end
endmodule

// File: rtl/fuse_pair_detect.sv
module fuse_pair_detect
  import fuse_pkg::*;
#(
  parameter int MAX_WAIT = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              hold_en_i,
  input  logic              old_valid_i,
  input  logic [INSN_W-1:0] old_insn_i,
  input  logic              young_valid_i,
  input  logic [INSN_W-1:0] young_insn_i,
  output logic              issue_valid_o,
  output logic              fuse_o,
  output logic [1:0]        consume_o,
  output logic [1:0]        desc_kind_o,
  output logic [INSN_W-1:0] desc_first_o,
  output logic [INSN_W-1:0] desc_second_o,
  output logic              desc_wb_en_o,
  output logic [DNUM_W-1:0] desc_wb_reg_o
);
  localparam int NSLOT = 2;

  insn_t            slot   [NSLOT];
  logic             base   [NSLOT];
  logic             form_a [NSLOT];
  logic             form_b [NSLOT];
  logic [REG_W-1:0] key    [NSLOT];

  assign slot[0] = insn_t'(old_insn_i);
  assign slot[1] = insn_t'(young_insn_i);

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    fuse_slot_qual #(.LEAD(g == 0)) u_qual (
      .insn_i    (slot[g]),
      .base_ok_o (base[g]),
      .form_a_o  (form_a[g]),
      .form_b_o  (form_b[g]),
      .key_reg_o (key[g])
    );
  end

  logic load_pair, store_pair, lead_cand, stall;

  fuse_pair_rules u_rules (
    .young_valid_i (young_valid_i),
    .o_base_i      (base[0]),
    .o_load_i      (form_a[0]),
    .o_alu_i       (form_b[0]),
    .o_key_i       (key[0]),
    .y_base_i      (base[1]),
    .y_alu_i       (form_a[1]),
    .y_store_i     (form_b[1]),
    .y_key_i       (key[1]),
    .load_pair_o   (load_pair),
    .store_pair_o  (store_pair),
    .lead_cand_o   (lead_cand)
  );

  fuse_wait_ctrl #(.MAX_WAIT(MAX_WAIT)) u_wait (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .flush_i       (flush_i),
    .hold_en_i     (hold_en_i),
    .old_valid_i   (old_valid_i),
    .young_valid_i (young_valid_i),
    .lead_cand_i   (lead_cand),
    .stall_o       (stall)
  );

  logic issue, fuse;
  assign issue = old_valid_i && !flush_i && !stall;
  assign fuse  = issue && (load_pair || store_pair);

  always_comb begin
    issue_valid_o = issue;
    fuse_o        = fuse;
    consume_o     = 2'd0;
    desc_kind_o   = KIND_NONE;
    desc_first_o  = '0;
    desc_second_o = '0;
    desc_wb_en_o  = 1'b0;
    desc_wb_reg_o = '0;
    if (issue) begin
      desc_first_o = old_insn_i;
      if (fuse) begin
        consume_o     = 2'd2;
        desc_kind_o   = load_pair ? KIND_LOAD_OP : KIND_OP_STORE;
        desc_second_o = young_insn_i;
        desc_wb_en_o  = 1'b1;
        // Dn is the older record's destination in both forms
        desc_wb_reg_o = slot[0].dst[DNUM_W-1:0];
      end else begin
        consume_o   = 2'd1;
        desc_kind_o = KIND_SINGLE;
      end
    end
  end
endmodule

// File: rtl/fuse_pair_detect_chk.sv
module fuse_pair_detect_chk
  import fuse_pkg::*;
#(
  parameter int MAX_WAIT = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              flush_i,
  input logic              old_valid_i,
  input logic [INSN_W-1:0] old_insn_i,
  input logic              young_valid_i,
  input logic [INSN_W-1:0] young_insn_i,
  input logic              issue_valid_o,
  input logic              fuse_o,
  input logic [1:0]        consume_o,
  input logic [1:0]        desc_kind_o,
  input logic              desc_wb_en_o
);
  insn_t o_r, y_r;
  assign o_r = insn_t'(old_insn_i);
  assign y_r = insn_t'(young_insn_i);

  int unsigned held_run;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) held_run <= 0;
    else if (old_valid_i && !issue_valid_o && !flush_i) held_run <= held_run + 1;
    else held_run <= 0;
  end

  assert_fuse_takes_two_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fuse_o |-> (consume_o == 2'd2) && (desc_kind_o >= 2'd2));
  assert_fuse_long_only_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fuse_o |-> (o_r.size == SZ_LONG) && (y_r.size == SZ_LONG));
  assert_fuse_one_word_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fuse_o |-> (o_r.len == LEN_ONE) && (y_r.len == LEN_ONE));
  assert_fuse_writes_back_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fuse_o |-> desc_wb_en_o);
  assert_no_fuse_alone_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !young_valid_i |-> !fuse_o);
  assert_hold_bounded_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (old_valid_i && !issue_valid_o && !flush_i) |-> (held_run < MAX_WAIT));
  assert_flush_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> !issue_valid_o && !fuse_o && (consume_o == 2'd0));
  assert_empty_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !old_valid_i |-> !issue_valid_o && (consume_o == 2'd0));
endmodule

bind fuse_pair_detect fuse_pair_detect_chk #(.MAX_WAIT(MAX_WAIT)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .flush_i       (flush_i),
  .old_valid_i   (old_valid_i),
  .old_insn_i    (old_insn_i),
  .young_valid_i (young_valid_i),
  .young_insn_i  (young_insn_i),
  .issue_valid_o (issue_valid_o),
  .fuse_o        (fuse_o),
  .consume_o     (consume_o),
  .desc_kind_o   (desc_kind_o),
  .desc_wb_en_o  (desc_wb_en_o)
);

// File: tb/tb_fuse_pair_detect.sv
module tb_fuse_pair_detect;
  localparam int W = 22;
  localparam int MAXW = 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic flush = 1'b0, hold = 1'b0, ov = 1'b0, yv = 1'b0;
  logic [W-1:0] oi = '0, yi = '0;
  logic iss, fz, wbe;
  logic [1:0] cons, kind;
  logic [W-1:0] d1, d2;
  logic [2:0] wbr;

  int checks = 0, errors = 0, mw = 0;

  always #4 clk = ~clk;

  fuse_pair_detect #(.MAX_WAIT(MAXW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush), .hold_en_i(hold),
    .old_valid_i(ov), .old_insn_i(oi), .young_valid_i(yv), .young_insn_i(yi),
    .issue_valid_o(iss), .fuse_o(fz), .consume_o(cons), .desc_kind_o(kind),
    .desc_first_o(d1), .desc_second_o(d2), .desc_wb_en_o(wbe), .desc_wb_reg_o(wbr)
  );

  function automatic logic [W-1:0] mk(int c, int sz, int s, int d, int m, int dir, int ln);
    return {2'(c), 2'(sz), 4'(s), 4'(d), 3'(m), 1'(dir), 3'd0, 3'(ln)};
  endfunction

  function automatic bit short_mode(int m);
    return m == 0 || m == 2 || m == 3 || m == 4;
  endfunction

  task automatic cyc(string req, bit f, bit h, bit ov_v, logic [W-1:0] o, bit yv_v, logic [W-1:0] y);
    bit bo, by, ld, st, cand, stl, e_iss, e_fz;
    int e_cons, e_kind;
    logic [W-1:0] e1, e2;
    logic [2:0] ewr;
    flush = f; hold = h; ov = ov_v; oi = o; yv = yv_v; yi = y;
    #2;
    bo = (o[19:18] == 2) && (o[2:0] == 1);
    by = (y[19:18] == 2) && (y[2:0] == 1);
    ld = (o[21:20] == 1) && !o[6] && !o[13] && short_mode(int'(o[9:7])) &&
         (y[21:20] == 2) && (y[17:14] == o[13:10]);
    st = (o[21:20] == 2) && !o[13] && (y[21:20] == 1) && y[6] &&
         short_mode(int'(y[9:7])) && (y[17:14] == o[13:10]);
    cand = bo && (((o[21:20] == 1) && !o[6] && !o[13] && short_mode(int'(o[9:7]))) ||
                  ((o[21:20] == 2) && !o[13]));
    stl = h && ov_v && !yv_v && cand && (mw < MAXW) && !f;
    e_iss = ov_v && !f && !stl;
    e_fz  = e_iss && yv_v && bo && by && (ld || st);
    e_cons = !e_iss ? 0 : (e_fz ? 2 : 1);
    e_kind = !e_iss ? 0 : (!e_fz ? 1 : (ld ? 2 : 3));
    e1 = e_iss ? o : '0;
    e2 = e_fz ? y : '0;
    ewr = e_fz ? o[12:10] : 3'd0;
    checks++;
    if (iss !== e_iss || fz !== e_fz || cons !== 2'(e_cons) || kind !== 2'(e_kind) ||
        d1 !== e1 || d2 !== e2 || wbe !== e_fz || wbr !== ewr) begin
      errors++;
      $display("FAIL %s: got iss=%0b fz=%0b cons=%0d kind=%0d d1=%h d2=%h wb=%0b/%0d exp iss=%0b fz=%0b cons=%0d kind=%0d d1=%h d2=%h wb=%0b/%0d",
               req, iss, fz, cons, kind, d1, d2, wbe, wbr,
               e_iss, e_fz, e_cons, e_kind, e1, e2, e_fz, ewr);
    end
    mw = stl ? mw + 1 : 0;
    @(posedge clk); #1;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] ldm, alu, alus, stm;
    ldm  = mk(1, 2, 8, 1, 3, 0, 1);  // move.l (a0)+ -> d1
    alu  = mk(2, 2, 1, 2, 0, 0, 1);  // op d1 -> d2
    alus = mk(2, 2, 5, 3, 0, 0, 1);  // op d5 -> d3
    stm  = mk(1, 2, 3, 9, 4, 1, 1);  // move.l d3 -> -(a1)
    #13 rst_n = 1'b1;
    @(posedge clk); #1;

    cyc("R12", 0, 0, 0, '0, 0, '0);
    cyc("R12", 0, 0, 0, ldm, 1, alu);
    // R1 load form over each short mode
    cyc("R1", 0, 0, 1, ldm, 1, alu);
    for (int m = 0; m < 8; m++) cyc("R5", 0, 0, 1, mk(1, 2, 8, 1, m, 0, 1), 1, alu);
    // R2 store form
    cyc("R2", 0, 0, 1, alus, 1, stm);
    for (int m = 0; m < 8; m++) cyc("R5", 0, 0, 1, alus, 1, mk(1, 2, 3, 9, m, 1, 1));
    // R3 sizes
    for (int s = 0; s < 4; s++) begin
      cyc("R3", 0, 0, 1, mk(1, s, 8, 1, 2, 0, 1), 1, alu);
      cyc("R3", 0, 0, 1, alus, 1, mk(1, s, 3, 9, 2, 1, 1));
    end
    // R4 lengths
    for (int l = 0; l < 4; l++) begin
      cyc("R4", 0, 0, 1, mk(1, 2, 8, 1, 2, 0, l), 1, alu);
      cyc("R4", 0, 0, 1, ldm, 1, mk(2, 2, 1, 2, 0, 0, l));
    end
    // R6 register linkage
    cyc("R6", 0, 0, 1, ldm, 1, mk(2, 2, 2, 2, 0, 0, 1));
    cyc("R6", 0, 0, 1, mk(1, 2, 8, 9, 2, 0, 1), 1, mk(2, 2, 9, 2, 0, 0, 1));
    cyc("R6", 0, 0, 1, mk(2, 2, 5, 11, 0, 0, 1), 1, mk(1, 2, 11, 9, 2, 1, 1));
    cyc("R6", 0, 0, 1, alus, 1, mk(1, 2, 4, 9, 2, 1, 1));
    // R6 interleaved window: mv->d1, mv->d0, op d1, op d0
    cyc("R6", 0, 0, 1, ldm, 1, mk(1, 2, 8, 0, 2, 0, 1));
    cyc("R6", 0, 0, 1, mk(1, 2, 8, 0, 2, 0, 1), 1, alu);
    cyc("R6", 0, 0, 1, alu, 1, mk(2, 2, 0, 3, 0, 0, 1));
    // R7 other-class pass-through
    cyc("R7", 0, 0, 1, mk(0, 2, 1, 1, 0, 0, 1), 1, alu);
    cyc("R7", 0, 0, 1, alu, 1, alus);
    // R8 write-back register varies
    for (int r = 0; r < 8; r++) cyc("R8", 0, 0, 1, mk(1, 2, 8, r, 2, 0, 1), 1, mk(2, 2, r, 7 - r, 0, 0, 1));
    // R9 lone record, hold off
    cyc("R9", 0, 0, 1, ldm, 0, '0);
    cyc("R9", 0, 0, 1, alus, 0, '0);
    // R10 hold: stall once then issue alone
    cyc("R10", 0, 1, 1, ldm, 0, '0);
    cyc("R10", 0, 1, 1, ldm, 0, '0);
    // R10 partner arrives after one held cycle
    cyc("R10", 0, 1, 1, alus, 0, '0);
    cyc("R10", 0, 1, 1, alus, 1, stm);
    // R10 non-candidate not held
    cyc("R10", 0, 1, 1, mk(1, 1, 8, 1, 2, 0, 1), 0, '0);
    cyc("R10", 0, 1, 1, mk(0, 2, 0, 0, 0, 0, 1), 0, '0);
    // R11 flush cancels hold and fusion
    cyc("R11", 0, 1, 1, ldm, 0, '0);
    cyc("R11", 1, 1, 1, ldm, 0, '0);
    cyc("R11", 0, 1, 1, ldm, 0, '0);
    cyc("R11", 0, 1, 1, ldm, 0, '0);
    cyc("R11", 1, 0, 1, ldm, 1, alu);
    cyc("R1", 0, 0, 1, ldm, 1, alu);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule